// File: doc/BRIEF.md
# Per-Device Address Retiming Unit

This unit sits between a processor that can issue addresses early (near the end of the previous clock cycle) and a memory map that mixes two kinds of device. Some devices can use an early address. Others are static RAM or ROM parts, which need the address to stay unchanged until after their access cycle has ended. The unit decodes the upper address bits of each access against a fixed region map. For an early-capable region it passes the processor address straight through. For a static region it presents a copy that is captured at the cycle boundary and held until the next one.

The unit also drives the processor's address-pipeline-enable control. The control turns on only while the current access targets an early-capable device. It is off out of reset, so the first access is safe for a static part. One-hot chip selects are decoded from the same address that leaves the unit on `memAddr`, so a select and its address always change together.

A cycle boundary is a rising clock edge at which `cycleEnd` is high. The access that begins at that edge is the "current access" until the next boundary.

Top module: `addr_retime_unit`

## Requirements
- R1: From reset until the first cycle boundary, `pipeEn` is 0, `chipSel` is all zeros and `memAddr` is 0, whatever `cpuAddr` and `cycleEnd` do while reset is asserted.
- R2: Region index = `cpuAddr[ADDR_W-1 -: REGION_BITS]`; `chipSel` is zero or one-hot, and when nonzero its set bit is the region index of `memAddr`.
- R3: When the current access was captured in a static region (`STATIC_MASK` bit = 1; default 4'b0101, so regions 0 and 2 are static), `memAddr` equals the address sampled at the boundary and stays unchanged until the next boundary, even while `cpuAddr` moves.
- R4: When the current access was captured in an early-capable region (mask bit = 0), `memAddr` equals `cpuAddr` in the same cycle, with no register delay.
- R5: At each boundary `pipeEn` becomes 1 if the captured region is early-capable and 0 if it is static. Between boundaries it does not change.
- R6: During an early-capable access, `chipSel` follows the live address. This holds even when the processor drives a next address in a static region before the boundary.
- R7: A boundary into a static region immediately after an early-capable access takes effect at that edge. The captured address is then held, and later `cpuAddr` changes do not appear on `memAddr`.
- R8: Back-to-back boundaries in static regions capture a new address at every edge, including the highest address of a static region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | ADDR_W | Address bus from the processor |
| cycleEnd | input | 1 | High on the edge that ends the current access and starts the next |
| pipeEn | output | 1 | Address-pipeline enable back to the processor |
| chipSel | output | 2**REGION_BITS | One-hot device select decoded from `memAddr` |
| memAddr | output | ADDR_W | Retimed address to the devices |

## Verification
Static and early-capable regions are each entered from reset, from each other and from themselves. Each time, `cpuAddr` is moved between boundaries. In a static access that movement must not reach `memAddr`. In an early access it must reach both `memAddr` and `chipSel` at once. This separates a correct hold from a register that is always loaded or never loaded. Addresses at region edges (0xBFFF, 0xC000, 0xFFFF) show whether the decoder uses the right upper bits. A burst of consecutive static boundaries checks that the capture fires on every boundary edge and not only on mode changes.

// File: rtl/arp_pkg.sv
package arp_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load held address at this edge
    logic useHeld;   // present held copy instead of live address
    logic selValid;  // a device may be selected
  } arpStrobes_t;
endpackage

// File: rtl/arp_region_decode.sv
module arp_region_decode #(
  parameter int REGION_BITS = 2,
  localparam int NUM_REGIONS = 1 << REGION_BITS
) (
  input  logic [REGION_BITS-1:0] regionAddr,
  output logic [NUM_REGIONS-1:0] sel
);
  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_sel
    assign sel[i] = (regionAddr == REGION_BITS'(i));
  end
endmodule

// File: rtl/arp_ctrl.sv
module arp_ctrl
  import arp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycleEnd,
  input  logic        liveStatic,
  output arpStrobes_t strobes,
  output logic        pipeEn
);
  logic started;
  logic curStatic;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started   <= 1'b0;
      curStatic <= 1'b1;
      pipeEn    <= 1'b0;
    end else if (cycleEnd) begin
      started   <= 1'b1;
      curStatic <= liveStatic;
      pipeEn    <= ~liveStatic;
    end
  end

  always_comb begin
    strobes.capture  = cycleEnd;
    strobes.useHeld  = ~started | curStatic;
    strobes.selValid = started;
  end
endmodule

// File: rtl/arp_datapath.sv
module arp_datapath
  import arp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REGION_BITS = 2,
  localparam int NUM_REGIONS = 1 << REGION_BITS,
  parameter logic [NUM_REGIONS-1:0] STATIC_MASK = 4'b0101
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  arpStrobes_t            strobes,
  output logic                   liveStatic,
  output logic [NUM_REGIONS-1:0] chipSel,
  output logic [ADDR_W-1:0]      memAddr
);
  logic [ADDR_W-1:0]      heldAddr;
  logic [NUM_REGIONS-1:0] liveSel;
  logic [NUM_REGIONS-1:0] outSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) heldAddr <= '0;
    else if (strobes.capture) heldAddr <= cpuAddr;
  end

  // attribute of the address the processor is driving now
  arp_region_decode #(.REGION_BITS(REGION_BITS)) u_liveDec (
    .regionAddr(cpuAddr[ADDR_W-1 -: REGION_BITS]),
    .sel       (liveSel)
  );
  assign liveStatic = |(liveSel & STATIC_MASK);

  assign memAddr = strobes.useHeld ? heldAddr : cpuAddr;

  // selects come from the outgoing address so both move together
  arp_region_decode #(.REGION_BITS(REGION_BITS)) u_outDec (
    .regionAddr(memAddr[ADDR_W-1 -: REGION_BITS]),
    .sel       (outSel)
  );
  assign chipSel = strobes.selValid ? outSel : '0;
endmodule

// File: rtl/addr_retime_unit.sv
module addr_retime_unit
  import arp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REGION_BITS = 2,
  localparam int NUM_REGIONS = 1 << REGION_BITS,
  parameter logic [NUM_REGIONS-1:0] STATIC_MASK = 4'b0101
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  logic                   cycleEnd,
  output logic                   pipeEn,
  output logic [NUM_REGIONS-1:0] chipSel,
  output logic [ADDR_W-1:0]      memAddr
);
  arpStrobes_t strobes;
  logic        liveStatic;

  arp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cycleEnd  (cycleEnd),
    .liveStatic(liveStatic),
    .strobes   (strobes),
    .pipeEn    (pipeEn)
  );

  arp_datapath #(
    .ADDR_W     (ADDR_W),
    .REGION_BITS(REGION_BITS),
    .STATIC_MASK(STATIC_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddr   (cpuAddr),
    .strobes   (strobes),
    .liveStatic(liveStatic),
    .chipSel   (chipSel),
    .memAddr   (memAddr)
  );
endmodule

// File: rtl/arp_checker.sv
module arp_checker #(
  parameter int ADDR_W = 16,
  parameter int REGION_BITS = 2,
  localparam int NUM_REGIONS = 1 << REGION_BITS,
  parameter logic [NUM_REGIONS-1:0] STATIC_MASK = 4'b0101
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      cpuAddr,
  input logic                   cycleEnd,
  input logic                   pipeEn,
  input logic [NUM_REGIONS-1:0] chipSel,
  input logic [ADDR_W-1:0]      memAddr
);
  logic sawBoundary;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sawBoundary <= 1'b0;
    else if (cycleEnd) sawBoundary <= 1'b1;
  end

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sawBoundary |-> (!pipeEn && chipSel == '0 && memAddr == '0));

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chipSel));

  // R2
  sel_matches_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel != '0) |-> chipSel[memAddr[ADDR_W-1 -: REGION_BITS]]);

  // R3
  static_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sawBoundary && !pipeEn && !cycleEnd) |=> $stable(memAddr));

  // R4
  early_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sawBoundary && pipeEn) |-> (memAddr == cpuAddr));

  // R5
  pipe_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cycleEnd |=> $stable(pipeEn));

  // R5
  pipe_follows_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleEnd |=> (pipeEn == !STATIC_MASK[$past(cpuAddr[ADDR_W-1 -: REGION_BITS])]));
endmodule

bind addr_retime_unit arp_checker #(
  .ADDR_W     (ADDR_W),
  .REGION_BITS(REGION_BITS),
  .STATIC_MASK(STATIC_MASK)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuAddr (cpuAddr),
  .cycleEnd(cycleEnd),
  .pipeEn  (pipeEn),
  .chipSel (chipSel),
  .memAddr (memAddr)
);

// File: tb/addr_retime_unit_tb.sv
module addr_retime_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam logic [3:0] MASK = 4'b0101;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic          cycleEnd = 1'b0;
  logic          pipeEn;
  logic [3:0]    chipSel;
  logic [AW-1:0] memAddr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_retime_unit u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cycleEnd(cycleEnd),
    .pipeEn(pipeEn), .chipSel(chipSel), .memAddr(memAddr)
  );

  function automatic logic [3:0] selOf(input logic [AW-1:0] a);
    return 4'b0001 << a[AW-1:AW-2];
  endfunction

  function automatic logic staticOf(input logic [AW-1:0] a);
    return MASK[a[AW-1:AW-2]];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // Boundary into address a; check the state the access should present
  task automatic boundary(input logic [AW-1:0] a, input string req);
    cpuAddr  = a;
    cycleEnd = 1'b1;
    tick();
    cycleEnd = 1'b0;
    #1;
    chk({req, " memAddr"}, 32'(memAddr), 32'(a));
    chk({req, " chipSel"}, 32'(chipSel), 32'(selOf(a)));
    chk({req, " pipeEn"}, 32'(pipeEn), 32'(!staticOf(a)));
  endtask

  task automatic test_reset();
    cpuAddr = 16'h4123;
    cycleEnd = 1'b1;
    tick();
    chk("R1 pipeEn in reset", 32'(pipeEn), 0);
    chk("R1 chipSel in reset", 32'(chipSel), 0);
    rstN = 1'b1;
    cycleEnd = 1'b0;
    tick();
    tick();
    chk("R1 pipeEn", 32'(pipeEn), 0);
    chk("R1 chipSel", 32'(chipSel), 0);
    chk("R1 memAddr", 32'(memAddr), 0);
  endtask

  task automatic test_static_hold();
    boundary(16'h1234, "R3 R5");
    cpuAddr = 16'h5678;
    #1;
    chk("R3 hold same cycle", 32'(memAddr), 32'h1234);
    tick();
    chk("R3 hold next cycle", 32'(memAddr), 32'h1234);
    chk("R2 sel held", 32'(chipSel), 32'h1);
    chk("R5 pipeEn steady", 32'(pipeEn), 0);
  endtask

  task automatic test_early_pass();
    boundary(16'h4AAA, "R4 R5");
    cpuAddr = 16'hC001;
    #1;
    chk("R4 live addr", 32'(memAddr), 32'hC001);
    chk("R6 live sel", 32'(chipSel), 32'h8);
    cpuAddr = 16'h8008;
    #1;
    chk("R6 early next static addr", 32'(memAddr), 32'h8008);
    chk("R6 early next static sel", 32'(chipSel), 32'h4);
    tick();
    chk("R5 pipeEn kept", 32'(pipeEn), 1);
  endtask

  task automatic test_early_to_static();
    boundary(16'h8008, "R7");
    cpuAddr = 16'h0000;
    tick();
    chk("R7 held after switch", 32'(memAddr), 32'h8008);
    chk("R7 sel after switch", 32'(chipSel), 32'h4);
  endtask

  task automatic test_edges_and_burst();
    boundary(16'hFFFF, "R2 top region");
    boundary(16'hC000, "R2 region3 base");
    boundary(16'hBFFF, "R8 static top");
    boundary(16'h0001, "R8 static burst a");
    boundary(16'h3FFF, "R8 static burst b");
    boundary(16'h8000, "R8 static burst c");
    cpuAddr = 16'h7FFF;
    tick();
    chk("R8 last burst held", 32'(memAddr), 32'h8000);
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_static_hold();
    test_early_pass();
    test_early_to_static();
    test_edges_and_burst();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule